// File: doc/BRIEF.md
# Variable-Length Synchronous Serial Port

This block moves characters of 2 to 16 bits over a three-wire synchronous serial link: a shift clock, a data output and a data input. One shift core serves both roles. As clock master it generates the shift clock from the system clock through a reload counter. As clock slave it follows a shift clock driven by an external device. Clock idle level and sampling phase can each be selected, which gives the four usual sampling modes. Either end of the character can go first, and a loopback switch feeds the data output back into the receiver so the port can test itself.

Parallel data enters and leaves as two valid/ready streams. The transmit stream has one holding word in front of the shifter. `tx_ready` is high exactly when that holding word is empty, so a second word can be queued while the first is shifting, and a third waits with `tx_valid` held high. The receive stream presents each finished character with `rx_valid`, which stays high until a cycle with `rx_ready`. The shifter cannot be stalled by the link. A character that finishes while the previous one is still unread replaces it and raises the error pulse. Three single-cycle interrupt pulses report a word leaving the holding register, a finished character, and an error.

Top module: `ssp_top`

## Requirements
- R1: The length code `cfg_len` selects code+1 bits per character. Codes 0 and 1 both select 2 bits. As master, `sclk_out` changes level exactly 2×bits times per character.
- R2: With `cfg_msb_first`=1, the bit at position bits−1 is shifted first and bit 0 last. With 0, bit 0 goes first. The same order applies on the data output and on the data input.
- R3: A finished character sits in `rx_data[bits-1:0]` and every bit above it reads 0.
- R4: As master, each half period of the shift clock lasts max(`cfg_baud`,1)+1 system clocks, so the fastest shift rate is system clock/4. Between characters `sclk_out` rests at `cfg_cpol`.
- R5: As slave (`cfg_master`=0), the port shifts on the edges of `sclk_in` after a two-stage synchronizer, and `sclk_out` stays at `cfg_cpol`.
- R6: The leading edge of each bit leaves the idle level and the trailing edge returns to it. With `cfg_cpha`=0, the first bit is on `sdo` before the first leading edge, input is sampled on leading edges, and output changes on trailing edges. With `cfg_cpha`=1, output changes on leading edges and input is sampled on trailing edges.
- R7: With `cfg_loop`=1, the receiver takes its input from `sdo` and ignores `sdi`, so the received character equals the transmitted one masked to its length.
- R8: `tx_ready` = holding word empty. A word is accepted on a cycle with `tx_valid` and `tx_ready` both high. When the shifter takes the word, the holding word empties and `tx_irq` pulses for one cycle.
- R9: At the end of each character, `rx_data` is updated, `rx_valid` is set and `rx_irq` pulses for one cycle. `rx_valid` and `rx_data` hold until a cycle with `rx_ready` high.
- R10: If a character ends while `rx_valid` is high and `rx_ready` is low, the new character replaces the old one and `err_irq` pulses.
- R11: As slave, a leading edge that arrives while no word has been loaded starts a character anyway. That character shifts zeros out, receives normally and pulses `err_irq`.
- R12: After reset `tx_ready`=1, `rx_valid`=0, `sdo`=0, all interrupt pulses are 0 and `sclk_out` equals `cfg_cpol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_len | input | 4 | Character length code (bits−1) |
| cfg_msb_first | input | 1 | 1: most significant bit first |
| cfg_master | input | 1 | 1: generate the shift clock |
| cfg_cpol | input | 1 | Shift clock idle level |
| cfg_cpha | input | 1 | Sampling phase select |
| cfg_loop | input | 1 | Internal loopback of data |
| cfg_baud | input | 16 | Half-period reload value |
| tx_data | input | 16 | Transmit word |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Holding word empty |
| rx_data | output | 16 | Received character, right-aligned |
| rx_valid | output | 1 | Received character available |
| rx_ready | input | 1 | Received character taken |
| sclk_in | input | 1 | External shift clock (slave role) |
| sclk_out | output | 1 | Generated shift clock (master role) |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output |
| tx_irq | output | 1 | Holding word moved to shifter |
| rx_irq | output | 1 | Character finished |
| err_irq | output | 1 | Overrun or slave underrun |

## Verification
The assertions assume that the configuration inputs change only while no character is in flight and no received character is pending. They also assume that an external master keeps each level of `sclk_in` for more than three system clocks and changes `sdi` away from the sampling edges. The stimulus changes the configuration only after the receive stream has been drained. As slave, it holds each shift clock level for ten system clocks. It changes `sdi` only at the edge opposite to the sampling edge, and it reads `sdo` just before that edge.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  // per-cycle shift events decoded from the active clock source
  typedef struct packed {
    logic edge_hit;  // a shift clock edge occurred this cycle
    logic lead;      // edge leaves the idle level
    logic drive;     // present next output bit
    logic sample;    // capture one input bit
    logic last;      // final edge of the character
  } ssp_ev_t;
endpackage

// File: rtl/ssp_baud.sv
module ssp_baud #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] div,
  output logic         tick
);
  logic [W-1:0] cnt;
  logic [W-1:0] reload;

  always_comb reload = (div == '0) ? W'(1) : div;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run)           cnt <= reload;
    else if (cnt == '0)      cnt <= reload;
    else                     cnt <= cnt - W'(1);
  end

  assign tick = run && (cnt == '0);
endmodule

// File: rtl/ssp_sync.sv
module ssp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic toggled
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], async_in};
      prev  <= chain[STAGES-1];
    end
  end

  assign level   = chain[STAGES-1];
  assign toggled = chain[STAGES-1] != prev;
endmodule

// File: rtl/ssp_shift.sv
module ssp_shift #(
  parameter int DW = 16,
  parameter int LW = 4,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          clear,
  input  logic          drive,
  input  logic          sample,
  input  logic          msb_first,
  input  logic [CW-1:0] nbits,
  input  logic [DW-1:0] load_data,
  input  logic          bit_in,
  output logic          dout,
  output logic [DW-1:0] rx_word
);
  logic [DW-1:0] txsr, tx_src, rxsr, rx_base;
  logic [LW-1:0] top_idx;

  always_comb begin
    top_idx = LW'(nbits - CW'(1));
    tx_src  = load ? load_data : (clear ? '0 : txsr);
    rx_base = (load || clear) ? '0 : rxsr;
    rx_word = rx_base;
    if (sample) begin
      if (msb_first) rx_word = {rx_base[DW-2:0], bit_in};
      else           rx_word = (rx_base >> 1) | (DW'(bit_in) << top_idx);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txsr <= '0;
      rxsr <= '0;
      dout <= 1'b0;
    end else begin
      rxsr <= rx_word;
      if (drive) begin
        dout <= msb_first ? tx_src[top_idx] : tx_src[0];
        txsr <= msb_first ? (tx_src << 1) : (tx_src >> 1);
      end else begin
        txsr <= tx_src;
      end
    end
  end
endmodule

// File: rtl/ssp_top.sv
module ssp_top import ssp_pkg::*; #(
  parameter int DW          = 16,
  parameter int BAUD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [$clog2(DW)-1:0] cfg_len,
  input  logic                  cfg_msb_first,
  input  logic                  cfg_master,
  input  logic                  cfg_cpol,
  input  logic                  cfg_cpha,
  input  logic                  cfg_loop,
  input  logic [BAUD_W-1:0]     cfg_baud,
  input  logic [DW-1:0]         tx_data,
  input  logic                  tx_valid,
  output logic                  tx_ready,
  output logic [DW-1:0]         rx_data,
  output logic                  rx_valid,
  input  logic                  rx_ready,
  input  logic                  sclk_in,
  output logic                  sclk_out,
  input  logic                  sdi,
  output logic                  sdo,
  output logic                  tx_irq,
  output logic                  rx_irq,
  output logic                  err_irq
);
  localparam int LW = $clog2(DW);
  localparam int CW = $clog2(DW + 1);
  localparam int EW = $clog2(2 * DW + 1);

  logic [CW-1:0] nbits;
  logic [EW-1:0] ecnt, end_cnt;
  logic [DW-1:0] txbuf, rx_word;
  logic          txfull, act, sclk_q;
  logic          tick, s_lvl, s_tog, dout, bit_in;
  logic          underrun, load, overrun;
  ssp_ev_t       ev;

  always_comb begin
    nbits   = (cfg_len < LW'(2)) ? CW'(2) : CW'(cfg_len) + CW'(1);
    end_cnt = (EW'(nbits) << 1) - EW'(1);
  end

  ssp_baud #(.W(BAUD_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(cfg_master && act),
    .div(cfg_baud), .tick(tick)
  );

  ssp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(sclk_in),
    .level(s_lvl), .toggled(s_tog)
  );

  // edge decode: a slave edge toward the idle level while idle is ignored
  always_comb begin
    ev.edge_hit = cfg_master ? tick : (s_tog && (act || (s_lvl != cfg_cpol)));
    ev.lead     = (ecnt[0] == 1'b0);
    ev.drive    = ev.edge_hit && (ev.lead == cfg_cpha);
    ev.sample   = ev.edge_hit && (ev.lead != cfg_cpha);
    ev.last     = ev.edge_hit && (ecnt == end_cnt);
    underrun    = !cfg_master && ev.edge_hit && !act;
    load        = !act && txfull && !underrun;
    overrun     = ev.last && rx_valid && !rx_ready;
  end

  assign bit_in = cfg_loop ? dout : sdi;

  ssp_shift #(.DW(DW), .LW(LW), .CW(CW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .clear(underrun),
    .drive(ev.drive || (load && !cfg_cpha)), .sample(ev.sample),
    .msb_first(cfg_msb_first), .nbits(nbits), .load_data(txbuf),
    .bit_in(bit_in), .dout(dout), .rx_word(rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txbuf    <= '0;
      txfull   <= 1'b0;
      act      <= 1'b0;
      ecnt     <= '0;
      sclk_q   <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      tx_irq   <= 1'b0;
      rx_irq   <= 1'b0;
      err_irq  <= 1'b0;
    end else begin
      if (tx_valid && tx_ready) begin
        txbuf  <= tx_data;
        txfull <= 1'b1;
      end else if (load) begin
        txfull <= 1'b0;
      end

      if (ev.last)                  act <= 1'b0;
      else if (load || underrun)    act <= 1'b1;

      if (ev.last)                  ecnt <= '0;
      else if (ev.edge_hit)         ecnt <= ecnt + EW'(1);

      if (cfg_master && ev.edge_hit) sclk_q <= ~sclk_q;

      if (ev.last) begin
        rx_data  <= rx_word;
        rx_valid <= 1'b1;
      end else if (rx_valid && rx_ready) begin
        rx_valid <= 1'b0;
      end

      tx_irq  <= load;
      rx_irq  <= ev.last;
      err_irq <= underrun || overrun;
    end
  end

  assign tx_ready = !txfull;
  assign sdo      = dout;
  assign sclk_out = cfg_master ? (sclk_q ^ cfg_cpol) : cfg_cpol;
endmodule

// File: rtl/ssp_chk.sv
module ssp_chk #(
  parameter int DW = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [$clog2(DW)-1:0] cfg_len,
  input logic                  cfg_master,
  input logic                  cfg_cpol,
  input logic                  tx_valid,
  input logic                  tx_ready,
  input logic [DW-1:0]         rx_data,
  input logic                  rx_valid,
  input logic                  rx_ready,
  input logic                  sclk_out,
  input logic                  tx_irq,
  input logic                  rx_irq
);
  localparam int LW = $clog2(DW);
  localparam int CW = $clog2(DW + 1);
  logic [CW-1:0] bits_exp;
  always_comb bits_exp = (cfg_len < LW'(2)) ? CW'(2) : CW'(cfg_len) + CW'(1);

  a_r8_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);
  a_r8_tx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq);
  a_r9_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid);
  a_r9_rx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);
  a_r10_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_irq || $stable(rx_data)));
  a_r3_right_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ((rx_data >> bits_exp) == '0));
  a_r5_slave_clk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_master |-> (sclk_out == cfg_cpol));
  a_r4_no_fast_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && !$stable(sclk_out) && $stable(cfg_cpol) && $stable(cfg_master))
      |=> $stable(sclk_out));
endmodule

bind ssp_top ssp_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_ssp_top.sv
module sim_ssp_top;
  localparam int CLK_P = 10;
  localparam int H     = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [3:0]  cfg_len = 4'd7;
  logic        cfg_msb_first = 1'b1, cfg_master = 1'b1, cfg_cpol = 1'b0;
  logic        cfg_cpha = 1'b0, cfg_loop = 1'b1;
  logic [15:0] cfg_baud = 16'd2, tx_data = '0, rx_data;
  logic        tx_valid = 1'b0, tx_ready, rx_valid, rx_ready = 1'b0;
  logic        sclk_in = 1'b0, sclk_out, sdi = 1'b1, sdo;
  logic        tx_irq, rx_irq, err_irq;

  int checks = 0, fails = 0, cyc = 0;
  int tog_cnt = 0, tog_gap = 0, last_tog = 0;
  int txi = 0, rxi = 0, eri = 0;
  logic prev_sclk = 1'b0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  ssp_top u0 (.*);

  always @(negedge clk) begin
    cyc++;
    if (tx_irq)  txi++;
    if (rx_irq)  rxi++;
    if (err_irq) eri++;
    if (sclk_out !== prev_sclk) begin
      tog_cnt++;
      tog_gap  = cyc - last_tog;
      last_tog = cyc;
    end
    prev_sclk = sclk_out;
  end

  // vector: master/loop, len code, msb, cpol, cpha, tx word, slave input word
  localparam logic [39:0] VEC [8] = '{
    {1'b1, 4'd7,  1'b1, 1'b0, 1'b0, 16'h00A5, 16'h0000},
    {1'b1, 4'd15, 1'b0, 1'b1, 1'b1, 16'hBEEF, 16'h0000},
    {1'b1, 4'd2,  1'b1, 1'b0, 1'b1, 16'hFFFD, 16'h0000},
    {1'b1, 4'd0,  1'b0, 1'b1, 1'b0, 16'hFFFE, 16'h0000},
    {1'b0, 4'd7,  1'b1, 1'b0, 1'b0, 16'h3C5A, 16'h00C3},
    {1'b0, 4'd11, 1'b0, 1'b0, 1'b1, 16'hF123, 16'h0ABC},
    {1'b0, 4'd4,  1'b1, 1'b1, 1'b0, 16'hFF11, 16'hFFEA},
    {1'b0, 4'd15, 1'b0, 1'b1, 1'b1, 16'h8001, 16'h5AA5}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_tx(input logic [15:0] w);
    @(negedge clk);
    tx_data  = w;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic read_rx();
    @(negedge clk);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic wait_rx();
    int t = 0;
    while (!rx_valid && t < 5000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic set_cfg(input logic m, input logic [3:0] code, input logic msb,
                         input logic cp, input logic ph);
    @(negedge clk);
    cfg_master = m; cfg_loop = m; cfg_len = code; cfg_msb_first = msb;
    cfg_cpol = cp; cfg_cpha = ph; sclk_in = cp; sdi = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // bench acts as external clock master
  task automatic slave_xfer(input int n, input logic msb, input logic cp, input logic ph,
                            input logic [15:0] sin, output logic [15:0] obs);
    obs = '0;
    for (int i = 0; i < n; i++) begin
      int idx = msb ? (n - 1 - i) : i;
      if (!ph) begin
        sdi = sin[idx];
        repeat (H) @(negedge clk);
        obs[idx] = sdo;
        sclk_in = ~cp;
        repeat (H) @(negedge clk);
        sclk_in = cp;
      end else begin
        sclk_in = ~cp;
        sdi = sin[idx];
        repeat (H) @(negedge clk);
        obs[idx] = sdo;
        sclk_in = cp;
        repeat (H) @(negedge clk);
      end
    end
    repeat (H) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 190000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic        m, msb, cp, ph;
    logic [3:0]  code;
    logic [15:0] txw, sinw, obs;
    int          n, t0, r0, e0, g0;
    logic [15:0] mask;

    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 tx_ready", 32'(tx_ready), 32'd1);
    chk("R12 rx_valid", 32'(rx_valid), 32'd0);
    chk("R12 sdo", 32'(sdo), 32'd0);
    chk("R12 irqs", {29'd0, tx_irq, rx_irq, err_irq}, 32'd0);
    chk("R12 sclk_out", 32'(sclk_out), 32'(cfg_cpol));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      {m, code, msb, cp, ph, txw, sinw} = VEC[v];
      n    = (code < 4'd2) ? 2 : int'(code) + 1;
      mask = 16'((32'h1 << n) - 1);
      cfg_baud = 16'd2;
      set_cfg(m, code, msb, cp, ph);
      g0 = tog_cnt; t0 = txi; r0 = rxi;
      if (m) begin
        write_tx(txw);
        wait_rx();
        repeat (2) @(negedge clk);
        chk("R7 R3 loopback data", 32'(rx_data), 32'(txw & mask));
        chk("R1 clock edges", 32'(tog_cnt - g0), 32'(2 * n));
        chk("R4 idle level", 32'(sclk_out), 32'(cp));
      end else begin
        write_tx(txw);
        repeat (6) @(negedge clk);
        slave_xfer(n, msb, cp, ph, sinw, obs);
        chk("R2 R6 slave sdo order", 32'(obs), 32'(txw & mask));
        chk("R2 R3 R6 slave rx data", 32'(rx_data), 32'(sinw & mask));
        chk("R5 slave sclk_out", 32'(sclk_out), 32'(cp));
      end
      chk("R9 rx_irq once", 32'(rxi - r0), 32'd1);
      chk("R8 tx_irq once", 32'(txi - t0), 32'd1);
      read_rx();
      chk("R9 rx_valid cleared", 32'(rx_valid), 32'd0);
    end

    // R4 fastest rate: reload 0 clamps to 1 -> 2 clocks per half period
    cfg_baud = 16'd0;
    set_cfg(1'b1, 4'd3, 1'b1, 1'b0, 1'b0);
    write_tx(16'h0009);
    wait_rx();
    repeat (2) @(negedge clk);
    chk("R4 min half period", 32'(tog_gap), 32'd2);
    read_rx();
    cfg_baud = 16'd5;
    set_cfg(1'b1, 4'd1, 1'b0, 1'b0, 1'b0);
    g0 = tog_cnt;
    write_tx(16'h0002);
    wait_rx();
    repeat (2) @(negedge clk);
    chk("R4 half period 6", 32'(tog_gap), 32'd6);
    chk("R1 code 1 gives 2 bits", 32'(tog_cnt - g0), 32'd4);
    chk("R7 R1 two bit data", 32'(rx_data), 32'd2);
    read_rx();

    // R8 double buffering and back-pressure, then R10 overrun
    cfg_baud = 16'd4;
    set_cfg(1'b1, 4'd15, 1'b1, 1'b0, 1'b0);
    t0 = txi; e0 = eri;
    write_tx(16'h1234);
    write_tx(16'hCAFE);
    chk("R8 holding word full", 32'(tx_ready), 32'd0);
    wait_rx();
    repeat (20) @(negedge clk);
    chk("R9 rx_valid held", 32'(rx_valid), 32'd1);
    chk("R9 rx_data held", 32'(rx_data), 32'h1234);
    chk("R10 no error yet", 32'(eri - e0), 32'd0);
    while (rxi < 1000 && (txi - t0) < 2) @(negedge clk);
    repeat (400) @(negedge clk);
    chk("R10 overrun error", 32'(eri - e0), 32'd1);
    chk("R10 newest kept", 32'(rx_data), 32'hCAFE);
    chk("R8 two loads", 32'(txi - t0), 32'd2);
    read_rx();

    // R11 slave underrun
    set_cfg(1'b0, 4'd7, 1'b0, 1'b0, 1'b1);
    t0 = txi; e0 = eri;
    slave_xfer(8, 1'b0, 1'b0, 1'b1, 16'h0096, obs);
    chk("R11 underrun error", 32'(eri - e0), 32'd1);
    chk("R11 zeros shifted", 32'(obs), 32'd0);
    chk("R11 rx still taken", 32'(rx_data), 32'h0096);
    chk("R11 no load", 32'(txi - t0), 32'd0);
    read_rx();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule